// File: doc/BRIEF.md
# Burst Bus Master with Slave Wait States

This block is the master side of a clocked shared bus where address and data travel on the same lines. A user-side agent hands it a transaction: a direction, a start address and a word count. The block then asks an external arbiter for the bus and waits for the grant. Once granted, it spends one cycle sending the direction together with the address. After that it moves the whole block of words with no further address cycles.

The addressed slave can hold off any data cycle by raising its wait line. While wait is low, words cross the bus on every clock. The master keeps its bus request asserted for the whole burst, even if the grant line drops, and lets go only after the final word. On the user side, write words are taken straight from an input port, with a strobe showing which word was consumed. Read words come back one cycle after they are sampled. A single-cycle completion pulse marks the end of each burst.

Top module: `sbm_burst_master`

## Requirements
- R1: While reset is low and in the first cycle after it, bus_req, bus_as, bus_ad_oe, done, rd_valid and wr_take are 0 and req_ready is 1.
- R2: bus_req rises in the cycle after a request is accepted. It stays high with bus_as and bus_ad_oe low for as long as bus_gnt is sampled low.
- R3: The cycle after bus_gnt is sampled high is the address cycle. In it, bus_as=1, bus_ad_oe=1 and bus_ad_out carries the start address. bus_rw is 1 for a write and 0 for a read, and it does not change while bus_req is high.
- R4: Each burst has exactly one address cycle, and bus_as stays low in every data cycle.
- R5: In each data cycle of a write, bus_ad_oe=1 and bus_ad_out equals wr_data. The word is consumed at the clock edge where bus_wait is 0, and wr_take is high exactly then. When bus_wait is 1, no word is consumed.
- R6: During the data cycles of a read, bus_ad_oe=0. The value of bus_ad_in is captured at each edge where bus_wait is 0. It appears on rd_data with a one-cycle rd_valid pulse in the next cycle, in bus order.
- R7: bus_req stays high from the request until the final word, whatever bus_gnt does. It is low in the cycle after the final word.
- R8: done is a one-cycle pulse, high in the cycle after the final word is transferred.
- R9: A word count of N moves N words. A count of 0 moves one word.
- R10: req_ready is high only while the block is idle. It is low from the cycle after acceptance up to the completion cycle.
- R11: With bus_wait low, words move on consecutive clocks. From the address cycle to the done cycle there are 1 + words + wait cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | User transaction request |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_addr | input | ADDR_W | Start address of the burst |
| req_len | input | LEN_W | Number of words (0 means one) |
| req_ready | output | 1 | Idle; a request is accepted this cycle |
| wr_data | input | DATA_W | Current write word from the user |
| wr_take | output | 1 | Current write word consumed at this edge |
| rd_data | output | DATA_W | Read word |
| rd_valid | output | 1 | rd_data holds a new word |
| done | output | 1 | Burst completed |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| bus_rw | output | 1 | Direction: 1 write, 0 read |
| bus_as | output | 1 | Address cycle strobe |
| bus_ad_out | output | max(ADDR_W,DATA_W) | Address/data lines driven by the master |
| bus_ad_oe | output | 1 | Master drives the address/data lines |
| bus_ad_in | input | max(ADDR_W,DATA_W) | Address/data lines as driven by the slave |
| bus_wait | input | 1 | Slave not ready; stall this data cycle |

## Verification
The hardest case to create is a wait cycle scattered through a long burst, mixed with a grant that drops during the data phase. The bench slave takes a per-vector bit mask of wait cycles, indexed by data-cycle number, and removes the grant as soon as the address cycle has been seen. From the same mask, the bench works out the exact cycle in which done must arrive. Wait is also held high outside the data phase to show that the master ignores it there. A reset in the middle of a read burst is applied as a directed case.

// File: rtl/sbm_pkg.sv
// Shared types for the burst bus master.
// Assumes: nothing beyond IEEE 1800-2017.
package sbm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARB  = 2'd1,
        ST_ADDR = 2'd2,
        ST_DATA = 2'd3
    } sbm_state_e;

    function automatic int sbm_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sbm_req_latch.sv
// Holds the direction and start address of the accepted transaction.
// Assumes: load is only asserted while the master is idle.
module sbm_req_latch #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              write_in,
    input  logic [ADDR_W-1:0] addr_in,
    output logic              write_q,
    output logic [ADDR_W-1:0] addr_q
);

    // Capture the request fields at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            write_q <= 1'b0;
            addr_q  <= '0;
        end else if (load) begin
            write_q <= write_in;
            addr_q  <= addr_in;
        end
    end

endmodule

// File: rtl/sbm_beat_counter.sv
// Counts the words still to move in a burst; a count of zero loads as one.
// Assumes: dec is only asserted on a completed data beat.
module sbm_beat_counter #(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] len_in,
    input  logic             dec,
    output logic             last
);

    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    logic [LEN_W-1:0] remaining;

    // Load the normalised count, then step down once per beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remaining <= '0;
        end else if (load) begin
            remaining <= (len_in == '0) ? ONE : len_in;
        end else if (dec) begin
            remaining <= remaining - ONE;
        end
    end

    // Flag the beat that finishes the burst.
    always_comb last = (remaining == ONE);

endmodule

// File: rtl/sbm_ctrl_fsm.sv
// Sequencer: idle, arbitration, single address cycle, data phase.
// Assumes: beat is only asserted in the data phase.
module sbm_ctrl_fsm
    import sbm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_fire,
    input  logic       gnt,
    input  logic       beat,
    input  logic       last,
    output sbm_state_e state,
    output logic       done_q
);

    sbm_state_e state_nx;

    // Next-state selection.
    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE: if (req_fire) state_nx = ST_ARB;
            ST_ARB:  if (gnt)      state_nx = ST_ADDR;
            ST_ADDR:               state_nx = ST_DATA;
            ST_DATA: if (beat && last) state_nx = ST_IDLE;
            default:               state_nx = ST_IDLE;
        endcase
    end

    // State register and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            done_q <= 1'b0;
        end else begin
            state  <= state_nx;
            done_q <= beat && last;
        end
    end

endmodule

// File: rtl/sbm_read_capture.sv
// Registers read words sampled from the shared lines on each read beat.
// Assumes: BUS_W >= DATA_W; the word sits in the low bits of the bus.
module sbm_read_capture #(
    parameter int DATA_W = 16,
    parameter int BUS_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [BUS_W-1:0]  bus_in,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    // One-cycle valid pulse with the captured word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= capture;
            if (capture) rd_data <= bus_in[DATA_W-1:0];
        end
    end

endmodule

// File: rtl/sbm_burst_master.sv
// Burst master for a clocked bus with shared address/data lines.
// Requests the bus, sends one address cycle, then moves the block of
// words, stalling while the slave holds wait; releases after the last word.
// Assumes: the arbiter keeps other masters off the bus while bus_req is high.
module sbm_burst_master
    import sbm_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int LEN_W  = 4,
    localparam int BUS_W = sbm_max(ADDR_W, DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    output logic              req_ready,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_take,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              done,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              bus_rw,
    output logic              bus_as,
    output logic [BUS_W-1:0]  bus_ad_out,
    output logic              bus_ad_oe,
    input  logic [BUS_W-1:0]  bus_ad_in,
    input  logic              bus_wait
);

    sbm_state_e        state;
    logic              req_fire;
    logic              beat;
    logic              last;
    logic              wr_q;
    logic [ADDR_W-1:0] addr_q;
    logic [BUS_W-1:0]  addr_ext;
    logic [BUS_W-1:0]  wdat_ext;

    // Handshake and beat qualification.
    always_comb begin
        req_ready = (state == ST_IDLE);
        req_fire  = req_valid && req_ready;
        beat      = (state == ST_DATA) && !bus_wait;
    end

    sbm_req_latch #(.ADDR_W(ADDR_W)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (req_fire),
        .write_in (req_write),
        .addr_in  (req_addr),
        .write_q  (wr_q),
        .addr_q   (addr_q)
    );

    sbm_beat_counter #(.LEN_W(LEN_W)) u_count (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (req_fire),
        .len_in (req_len),
        .dec    (beat),
        .last   (last)
    );

    sbm_ctrl_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_fire (req_fire),
        .gnt      (bus_gnt),
        .beat     (beat),
        .last     (last),
        .state    (state),
        .done_q   (done)
    );

    sbm_read_capture #(.DATA_W(DATA_W), .BUS_W(BUS_W)) u_rcap (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (beat && !wr_q),
        .bus_in   (bus_ad_in),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    // Widen address and write word to the shared line width.
    always_comb begin
        addr_ext = '0;
        addr_ext[ADDR_W-1:0] = addr_q;
        wdat_ext = '0;
        wdat_ext[DATA_W-1:0] = wr_data;
    end

    // Bus-side outputs derived from the phase.
    always_comb begin
        bus_req    = (state != ST_IDLE);
        bus_as     = (state == ST_ADDR);
        bus_rw     = wr_q;
        bus_ad_oe  = bus_as || ((state == ST_DATA) && wr_q);
        wr_take    = beat && wr_q;
        bus_ad_out = '0;
        if (bus_as)                   bus_ad_out = addr_ext;
        else if ((state == ST_DATA) && wr_q) bus_ad_out = wdat_ext;
    end

endmodule

// File: rtl/sbm_burst_master_chk.sv
// Protocol checker for the burst master, bound into every instance.
// Assumes: signal names match the top module ports.
module sbm_burst_master_chk (
    input logic clk,
    input logic rst_n,
    input logic req_ready,
    input logic wr_take,
    input logic rd_valid,
    input logic done,
    input logic bus_req,
    input logic bus_gnt,
    input logic bus_rw,
    input logic bus_as,
    input logic bus_ad_oe,
    input logic bus_wait
);

    AST_ADDR_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        bus_as |-> $past(bus_req && bus_gnt && !bus_as && !bus_ad_oe)); // R2
    AST_RW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && $past(bus_req)) |-> $stable(bus_rw)); // R3
    AST_SINGLE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        bus_as |=> !bus_as); // R4
    AST_TAKE_ON_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_take |-> (!bus_wait && bus_ad_oe && !bus_as && bus_rw)); // R5
    AST_READ_AFTER_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(bus_req && !bus_ad_oe && !bus_wait && !bus_as)); // R6
    AST_DRIVE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ad_oe || bus_as) |-> bus_req); // R7
    AST_RELEASE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!bus_req && $past(bus_req))); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !bus_req); // R10

endmodule

bind sbm_burst_master sbm_burst_master_chk u_chk (.*);

// File: tb/tb_sbm_burst_master.sv
// Self-checking bench: vector table of bursts against a behavioural slave,
// then directed reset cases.
module tb_sbm_burst_master;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [3:0]  req_len = '0;
    logic        req_ready;
    logic [15:0] wr_data = '0;
    logic        wr_take;
    logic [15:0] rd_data;
    logic        rd_valid;
    logic        done;
    logic        bus_req;
    logic        bus_gnt = 1'b0;
    logic        bus_rw;
    logic        bus_as;
    logic [15:0] bus_ad_out;
    logic        bus_ad_oe;
    logic [15:0] bus_ad_in = '0;
    logic        bus_wait = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    sbm_burst_master dut (.*);

    // {write, addr, len, wait mask by data cycle, grant delay}
    localparam int NV = 7;
    localparam logic [40:0] VECS [NV] = '{
        {1'b1, 16'h1234, 4'd4,  16'h0000, 4'd0},
        {1'b0, 16'hBEEF, 4'd3,  16'h0000, 4'd2},
        {1'b1, 16'h0F00, 4'd5,  16'h0023, 4'd1},
        {1'b0, 16'hA5A0, 4'd0,  16'h0007, 4'd3},
        {1'b1, 16'h7FFE, 4'd0,  16'h0000, 4'd0},
        {1'b0, 16'h0040, 4'd15, 16'h8411, 4'd1},
        {1'b0, 16'h0001, 4'd1,  16'h0001, 4'd0}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] wdat(input logic [15:0] a, input int k);
        return a + 16'(16'h0101 * (k + 1));
    endfunction

    function automatic logic [15:0] rdat(input logic [15:0] a, input int k);
        return ~a ^ 16'(16'h0011 * k);
    endfunction

    function automatic int data_cycles(input logic [15:0] mask, input int n);
        int c = 0;
        int got = 0;
        while (got < n) begin
            if (!(c < 16 && mask[c])) got++;
            c++;
        end
        return c;
    endfunction

    task automatic run_txn(input logic [40:0] v);
        logic        wr   = v[40];
        logic [15:0] addr = v[39:24];
        logic [3:0]  len  = v[23:20];
        logic [15:0] mask = v[19:4];
        int          gd   = int'(v[3:0]);
        int eff = (len == 0) ? 1 : int'(len);
        int cyc = 0, gcnt = 0, dc = 0, widx = 0, rcnt = 0, as_cnt = 0, as_cyc = 0;
        bit in_data = 0, got_done = 0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R10 ready before request", req_ready, 1);
        req_valid = 1'b1; req_write = wr; req_addr = addr; req_len = len;
        @(negedge clk);
        req_valid = 1'b0;
        while (!got_done && cyc < 300) begin
            if (done) in_data = 0;
            if (cyc == 0) chk(bus_req == 1'b1, "R2 request after accept", bus_req, 1);
            bus_gnt = (as_cnt == 0) && !bus_as && (gcnt >= gd);
            gcnt++;
            bus_wait = in_data ? ((dc < 16) ? mask[dc] : 1'b0) : 1'b1;
            bus_ad_in = in_data ? rdat(addr, widx) : 16'hDEAD;
            wr_data = wdat(addr, widx);
            #1;
            if (rd_valid) begin
                chk(rcnt < eff && rd_data == rdat(addr, rcnt), "R6 read word", rd_data, rdat(addr, rcnt));
                rcnt++;
            end
            if (as_cnt == 0 && !bus_as && !done)
                chk(!bus_ad_oe && bus_req, "R2 no drive before grant", {bus_ad_oe, bus_req}, 1);
            if (bus_as) begin
                as_cnt++;
                if (as_cnt == 1) begin
                    as_cyc = cyc;
                    chk(bus_ad_out == addr && bus_ad_oe, "R3 address cycle", bus_ad_out, addr);
                    chk(bus_rw == wr, "R3 direction", bus_rw, wr);
                    chk(req_ready == 1'b0, "R10 busy", req_ready, 0);
                end
            end
            if (in_data) begin
                chk(bus_req == 1'b1, "R7 bus held", bus_req, 1);
                if (wr) begin
                    chk(bus_ad_oe && bus_ad_out == wdat(addr, widx), "R5 write word", bus_ad_out, wdat(addr, widx));
                    chk(wr_take == !bus_wait, "R5 take on beat", wr_take, !bus_wait);
                end else begin
                    chk(!bus_ad_oe && !wr_take, "R6 lines released", {bus_ad_oe, wr_take}, 0);
                end
                if (!bus_wait) widx++;
                dc++;
            end
            if (done) begin
                got_done = 1;
                chk(bus_req == 1'b0, "R7 release after last", bus_req, 0);
                chk(req_ready == 1'b1, "R10 ready at done", req_ready, 1);
                chk(widx == eff, "R9 word count", widx, eff);
                chk(cyc - as_cyc == 1 + data_cycles(mask, eff), "R11 burst length",
                    cyc - as_cyc, 1 + data_cycles(mask, eff));
                chk(as_cnt == 1, "R4 single address", as_cnt, 1);
                if (!wr) chk(rcnt == eff, "R6 read count", rcnt, eff);
            end
            if (bus_as) in_data = 1;
            @(negedge clk);
            cyc++;
        end
        if (!got_done) chk(1'b0, "R8 done never seen", 0, 1);
        chk(done == 1'b0, "R8 done single pulse", done, 0);
        bus_wait = 1'b0;
    endtask

    task automatic chk_idle(input string tag);
        chk(!bus_req && !bus_as && !bus_ad_oe && !done && !rd_valid && !wr_take && req_ready,
            tag, {bus_req, bus_as, bus_ad_oe, done, rd_valid, wr_take, req_ready}, 7'b0000001);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 chk_idle("R1 in reset");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1 chk_idle("R1 after reset");

        for (int i = 0; i < NV; i++) run_txn(VECS[i]);

        // Reset in the middle of a read burst.
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h3300; req_len = 4'd8;
        bus_gnt = 1'b1; bus_wait = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        #1 chk_idle("R1 reset mid-burst");
        rst_n = 1'b1;
        bus_gnt = 1'b0;
        repeat (2) @(negedge clk);
        #1 chk_idle("R1 stays idle after reset");

        // A fresh burst works after the interrupted one.
        run_txn({1'b1, 16'h00F0, 4'd2, 16'h0002, 4'd0});

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule